// File: doc/BRIEF.md
# Supervisory Reset Generator

The block turns a digital "primary supply good" comparator result and an active-low manual-reset pin into the system reset. Reset is held while the supply is low or the manual-reset pin is held down. Once both conditions have cleared, it stays asserted for a hold time chosen at runtime by a two-bit select. Any new fault during the hold throws the count away. The count then starts again from zero once the fault clears.

All three inputs pass through two-flop synchronizers. The manual-reset pin also passes through a filter, so a press must last a set number of clock cycles before it is acted on. The block also gives an early low-line flag and a secondary-supply fail flag. Neither flag waits for the hold time. It further gives one-cycle event pulses that a fault register can latch. The hold time is counted in ticks, and each tick is a fixed number of clock cycles. Short values can therefore be used to scale every hold time down.

Top module: `sup_reset_gen`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it is released, reset is asserted, `lowline_no` and `v2fail_no` are 0, and all event outputs are 0.
- R2: `pup_sel_i` selects the hold length in ticks. Code 00 gives UNIT_TICKS, 01 gives 4×UNIT_TICKS, 10 gives 8×UNIT_TICKS and 11 gives 16×UNIT_TICKS. One tick is TICK_DIV clock cycles.
- R3: `supply_ok_i` rises with `mr_ni` already high and filtered as released. Reset deasserts exactly 2 + hold cycles later, where hold is the R2 length in clock cycles.
- R4: `supply_ok_i` going low asserts reset at the third rising edge after the change. Each fault discards the hold progress made so far, so a later release again takes the full R3 latency.
- R5: A low level on `mr_ni` that is sampled on fewer than FILT_LEN consecutive cycles has no effect on reset or `ev_mr_o`. A low level of FILT_LEN or more cycles asserts reset.
- R6: When `mr_ni` is released with the supply good, reset deasserts 2 + FILT_LEN + hold cycles after the release.
- R7: `lowline_no` equals `supply_ok_i` delayed by two clock edges, with no hold time.
- R8: `v2fail_no` equals `v2_ok_i` delayed by two clock edges, with no hold time. It has no effect on reset.
- R9: `ev_lv1_o`, `ev_lv2_o` and `ev_mr_o` each pulse high for exactly one cycle on the onset of their fault. These are the synchronized supply falling, the synchronized v2 falling, and the filtered manual reset going low.
- R10: With ACTIVE_HIGH = 0, `sys_rst_o` is low when reset is asserted. With ACTIVE_HIGH = 1, it is high when reset is asserted.
- R11: A fault seen on the same edge as the final hold tick wins, and reset stays asserted with no release pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| supply_ok_i | input | 1 | Primary supply comparator, 1 = above threshold |
| v2_ok_i | input | 1 | Secondary supply comparator, 1 = above threshold |
| mr_ni | input | 1 | Manual reset pin, active low |
| pup_sel_i | input | 2 | Hold time select |
| sys_rst_o | output | 1 | System reset, polarity set by ACTIVE_HIGH |
| lowline_no | output | 1 | Early low-supply flag, active low |
| v2fail_no | output | 1 | Secondary supply fail flag, active low |
| ev_lv1_o | output | 1 | Pulse on primary supply fault onset |
| ev_lv2_o | output | 1 | Pulse on secondary supply fault onset |
| ev_mr_o | output | 1 | Pulse on filtered manual reset onset |

## Verification
The hold counter's final tick and a new supply fault can land on the same clock edge. The bench provokes this by releasing the manual reset and then dropping the supply after a delay. It sweeps that delay across a window around the computed release edge. For each delay, the bench predicts by arithmetic whether a release pulse must appear, and it judges each case by whether the reset output ever deasserts before the fault reasserts it.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
  function automatic int unsigned hold_mult(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/mr_filter.sv
module mr_filter #(
  parameter int unsigned FILT_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mr_s_i,
  output logic mr_f_o
);
  localparam int unsigned FW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  logic [FW-1:0] cnt_q;
  logic          mr_f_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mr_f_q <= 1'b1;
    end else if (mr_s_i == mr_f_q) begin
      cnt_q <= '0;
    end else if (cnt_q == FW'(FILT_LEN - 1)) begin
      mr_f_q <= mr_s_i;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
  assign mr_f_o = mr_f_q;

  p_filter_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mr_s_i == mr_f_q) |=> $stable(mr_f_q));
endmodule

// File: rtl/hold_timer.sv
module hold_timer
  import sup_rst_pkg::*;
#(
  parameter int unsigned TICK_DIV   = 1000,
  parameter int unsigned UNIT_TICKS = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fault_i,
  input  logic [1:0] sel_i,
  output logic       rst_act_o
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned HW = $clog2(16 * UNIT_TICKS + 1);

  logic [PW-1:0] pre_q;
  logic [HW-1:0] hcnt_q, target;
  logic          rst_act_q, tick;

  assign target = HW'(UNIT_TICKS * hold_mult(sel_i));
  assign tick   = (pre_q == PW'(TICK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_act_q <= 1'b1;
      pre_q     <= '0;
      hcnt_q    <= '0;
    end else if (fault_i) begin
      rst_act_q <= 1'b1;
      pre_q     <= '0;
      hcnt_q    <= '0;
    end else if (rst_act_q) begin
      if (tick) begin
        pre_q <= '0;
        if (({1'b0, hcnt_q} + 1'b1) >= {1'b0, target}) begin
          rst_act_q <= 1'b0;
          hcnt_q    <= '0;
        end else begin
          hcnt_q <= hcnt_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
  assign rst_act_o = rst_act_q;

  p_fault_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> (rst_act_q && pre_q == '0 && hcnt_q == '0));
  p_release_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_act_q && !tick) |=> rst_act_q);
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter bit          ACTIVE_HIGH = 1'b0,
  parameter int unsigned TICK_DIV    = 1000,
  parameter int unsigned UNIT_TICKS  = 50,
  parameter int unsigned FILT_LEN    = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       v2_ok_i,
  input  logic       mr_ni,
  input  logic [1:0] pup_sel_i,
  output logic       sys_rst_o,
  output logic       lowline_no,
  output logic       v2fail_no,
  output logic       ev_lv1_o,
  output logic       ev_lv2_o,
  output logic       ev_mr_o
);
  logic [2:0] syn;
  logic       sup_s, v2_s, mr_s, mr_f, fault, rst_act;
  logic [2:0] prev_q, cur;

  sync_chain #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni, .d_i({mr_ni, v2_ok_i, supply_ok_i}), .q_o(syn));
  assign sup_s = syn[0];
  assign v2_s  = syn[1];
  assign mr_s  = syn[2];

  mr_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk_i, .rst_ni, .mr_s_i(mr_s), .mr_f_o(mr_f));

  assign fault = ~sup_s | ~mr_f;

  hold_timer #(.TICK_DIV(TICK_DIV), .UNIT_TICKS(UNIT_TICKS)) u_hold (
    .clk_i, .rst_ni, .fault_i(fault), .sel_i(pup_sel_i), .rst_act_o(rst_act));

  // onset pulses: previous high, current low
  assign cur = {mr_f, v2_s, sup_s};
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 3'b100;
    else         prev_q <= cur;
  end
  assign ev_lv1_o = prev_q[0] & ~cur[0];
  assign ev_lv2_o = prev_q[1] & ~cur[1];
  assign ev_mr_o  = prev_q[2] & ~cur[2];

  assign lowline_no = sup_s;
  assign v2fail_no  = v2_s;

  generate
    if (ACTIVE_HIGH) begin : g_hi
      assign sys_rst_o = rst_act;
    end else begin : g_lo
      assign sys_rst_o = ~rst_act;
    end
  endgenerate

  p_lowline_forces_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lowline_no |=> rst_act);
  p_ev_lv1_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_lv1_o |=> !ev_lv1_o);
  p_ev_mr_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_mr_o |=> (!ev_mr_o && rst_act));
  p_ev_lv2_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_lv2_o |=> !ev_lv2_o);
endmodule

// File: tb/sup_reset_gen_test.sv
module sup_reset_gen_test;
  localparam int TD = 3, UT = 2, FL = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sup = 1'b0, v2 = 1'b0, mr = 1'b1;
  logic [1:0] sel = 2'b00;
  logic rst_lo, rst_hi, ll_n, v2f_n, e1, e2, em;
  logic rst_hi_b, ll_b, v2_b, e1_b, e2_b, em_b;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  sup_reset_gen #(.ACTIVE_HIGH(1'b0), .TICK_DIV(TD), .UNIT_TICKS(UT), .FILT_LEN(FL)) uut (
    .clk_i(clk), .rst_ni, .supply_ok_i(sup), .v2_ok_i(v2), .mr_ni(mr), .pup_sel_i(sel),
    .sys_rst_o(rst_lo), .lowline_no(ll_n), .v2fail_no(v2f_n),
    .ev_lv1_o(e1), .ev_lv2_o(e2), .ev_mr_o(em));
  sup_reset_gen #(.ACTIVE_HIGH(1'b1), .TICK_DIV(TD), .UNIT_TICKS(UT), .FILT_LEN(FL)) uut_hi (
    .clk_i(clk), .rst_ni, .supply_ok_i(sup), .v2_ok_i(v2), .mr_ni(mr), .pup_sel_i(sel),
    .sys_rst_o(rst_hi_b), .lowline_no(ll_b), .v2fail_no(v2_b),
    .ev_lv1_o(e1_b), .ev_lv2_o(e2_b), .ev_mr_o(em_b));
  assign rst_hi = rst_hi_b;

  function automatic int hold_cyc(input logic [1:0] s);
    int m;
    m = (s == 2'd0) ? 1 : (s == 2'd1) ? 4 : (s == 2'd2) ? 8 : 16;
    return m * UT * TD;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // posedges until reset observed released
  task automatic lat(output int n);
    n = 0;
    while (n < 1000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (rst_lo) break;
    end
  endtask

  task automatic restart(input logic [1:0] s, input logic sup_v, input logic mr_v);
    @(negedge clk);
    rst_ni = 1'b0; sel = s; sup = sup_v; mr = mr_v;
    cyc(1);
    rst_ni = 1'b1;
    cyc(FL + 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    bit seen;
    @(negedge clk);
    // R1 reset state
    check(rst_lo == 1'b0 && rst_hi == 1'b1, "R1 reset asserted in reset", {rst_lo, rst_hi}, 1);
    check(ll_n == 0 && v2f_n == 0 && e1 == 0 && e2 == 0 && em == 0, "R1 flags in reset",
          {ll_n, v2f_n, e1, e2, em}, 0);
    rst_ni = 1'b1;
    cyc(1);
    check(rst_lo == 1'b0 && e1 == 0 && em == 0, "R1 first cycle after reset", {rst_lo, e1, em}, 0);

    // R2 R3 power-up latency per select
    for (int s = 0; s < 4; s++) begin
      restart(2'(s), 1'b0, 1'b1);
      sup = 1'b1;
      lat(n);
      check(n == 2 + hold_cyc(2'(s)), $sformatf("R2 R3 sel=%0d release latency", s), n,
            2 + hold_cyc(2'(s)));
      check(rst_hi == 1'b0, "R10 active-high released", rst_hi, 0);
    end

    // R4 R7 R9 supply drop timing
    sup = 1'b0;
    cyc(2);
    check(ll_n == 0 && rst_lo == 1, "R7 lowline after 2 edges, reset not yet", {ll_n, rst_lo}, 2'b01);
    check(e1 == 1, "R9 ev_lv1 pulse", e1, 1);
    cyc(1);
    check(rst_lo == 0 && e1 == 0, "R4 reset at third edge, R9 single pulse", {rst_lo, e1}, 0);
    check(rst_hi == 1, "R10 active-high asserted", rst_hi, 1);

    // R4 restart of hold count
    sel = 2'b01;
    sup = 1'b1;
    cyc(12);
    check(rst_lo == 0, "R4 still holding mid count", rst_lo, 0);
    sup = 1'b0;
    cyc(5);
    sup = 1'b1;
    lat(n);
    check(n == 2 + hold_cyc(2'b01), "R4 full hold after restart", n, 2 + hold_cyc(2'b01));

    // R5 manual reset filter sweep
    for (int l = 1; l <= FL + 2; l++) begin
      cyc(3);
      seen = 0;
      mr = 1'b0;
      for (int k = 0; k < l; k++) begin
        @(posedge clk); @(negedge clk);
        if (!rst_lo || em) seen = 1;
      end
      mr = 1'b1;
      for (int k = 0; k < FL + 4; k++) begin
        @(posedge clk); @(negedge clk);
        if (!rst_lo || em) seen = 1;
      end
      check(seen == (l >= FL), $sformatf("R5 mr low %0d cycles", l), seen, l >= FL);
      if (seen) begin
        lat(n);
      end
    end

    // R6 manual reset release latency per select
    for (int s = 0; s < 4; s++) begin
      restart(2'(s), 1'b1, 1'b0);
      mr = 1'b1;
      lat(n);
      check(n == 2 + FL + hold_cyc(2'(s)), $sformatf("R6 sel=%0d mr release latency", s), n,
            2 + FL + hold_cyc(2'(s)));
    end

    // R8 v2 path, no effect on reset
    v2 = 1'b1;
    cyc(1);
    check(v2f_n == 0, "R8 v2 not yet after 1 edge", v2f_n, 0);
    cyc(1);
    check(v2f_n == 1 && rst_lo == 1, "R8 v2 after 2 edges", {v2f_n, rst_lo}, 2'b11);
    v2 = 1'b0;
    cyc(2);
    check(v2f_n == 0 && e2 == 1 && rst_lo == 1, "R8 R9 v2 fall, pulse, reset unaffected",
          {v2f_n, e2, rst_lo}, 3'b011);
    cyc(1);
    check(e2 == 0, "R9 ev_lv2 single pulse", e2, 0);

    // R11 fault on the final tick edge
    for (int d = 6; d <= 14; d++) begin
      restart(2'b00, 1'b1, 1'b0);
      mr = 1'b1;
      seen = 0;
      for (int k = 1; k <= 22; k++) begin
        @(posedge clk); @(negedge clk);
        if (rst_lo) seen = 1;
        if (k == d) sup = 1'b0;
      end
      check(seen == (d >= 2 + FL + hold_cyc(2'b00) - 2), $sformatf("R11 fault delay %0d", d),
            seen, d >= 2 + FL + hold_cyc(2'b00) - 2);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule